// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block deserializes an audio serial stream whose bit clock, word-select and data lines come from an external master. The block is a slave on both clocks. All three lines are brought into the system clock domain through two-flop synchronizers. Edges of the bit clock are found by comparing successive synchronized samples. On every sampling edge the block reads one data bit and the word-select level, and it finds word boundaries by the rules of the selected framing convention. A completed word is aligned, sign-extended to the output width and presented on a valid/ready output together with its channel or word index.

Five framings are decoded. Three are two-channel conventions: the classic stereo framing, left-justified and right-justified. Two are multi-word frame-sync conventions, one with a single-period sync pulse and one with a long sync pulse. A configuration byte selects the framing, the bit order and the polarities of the bit clock and word select. An options byte can route the local transmitter's serial output into the receive path for loopback testing. The word length is a run-time input. When a new word completes while the previous one is still unaccepted, the new word replaces it and an overrun pulse is raised.

Top module: `aud_ser_rx`

## Requirements
- R1: Bit clock, word select and serial data each pass through a two-flop synchronizer. The system clock must be at least four times the bit clock. A word appears on `valid_o` at the third rising system clock edge after the pin transition that forms the sampling edge of its final bit.
- R2: With `fmt_i[2:0]`=0 (stereo framing), data and word select are sampled on bit clock rising edges. The first bit of a word is the one sampled one bit period after a word-select change. The bit sampled at the change itself belongs to the previous slot. Word select low gives index 0 and high gives index 1.
- R3: With `fmt_i[2:0]`=3 (left-justified), sampling is on rising edges. The first bit is the one sampled in the same period in which the word-select change is seen. Word select high gives index 0 and low gives index 1.
- R4: With `fmt_i[2:0]`=4 (right-justified), sampling is on rising edges. A word is emitted when a word-select change is seen, built from the last `wlen_i` bits sampled before that change. The index is 0 if word select was high during the slot and 1 if it was low. The first slot after reset is not emitted at its start.
- R5: With `fmt_i[2:0]`=1 (short sync), sampling is on falling edges. A sample with word select high arms a frame. The next bit starts word 0, and further words follow back to back with indices 1, 2 and so on until the next sync sample.
- R6: With `fmt_i[2:0]`=2 (long sync), sampling is on falling edges. The first sample with word select high after a low sample starts word 0 with that same bit. Words follow back to back, and the falling edge of word select has no effect.
- R7: `fmt_i[3]`=0 takes bits most significant first. `fmt_i[3]`=1 takes them least significant first. This applies to every framing.
- R8: `fmt_i[4]`=1 inverts the bit clock pin and `fmt_i[5]`=1 inverts the word-select pin before decoding.
- R9: `opt_i[7]`=1 takes serial data from `lb_sd_i` and ignores `sd_i`. `opt_i[7]`=0 takes it from `sd_i` and ignores `lb_sd_i`.
- R10: `data_o` carries the `wlen_i`-bit word sign-extended to the output width, with bit `wlen_i`-1 taken as the sign.
- R11: After reset `valid_o`, `overrun_o`, `data_o` and `idx_o` are zero. A presented word stays valid and stable until `ready_i` is high. If a new word completes while a word is still unaccepted, the new word replaces it and `overrun_o` pulses for one cycle.
- R12: Framing codes 5, 6 and 7 produce no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select / frame sync |
| sd_i | input | 1 | External serial data |
| lb_sd_i | input | 1 | Local transmitter serial output, used in loopback |
| fmt_i | input | 8 | [2:0] framing code, [3] LSB first, [4] bit clock invert, [5] word select invert |
| opt_i | input | 8 | [7] loopback select |
| wlen_i | input | LEN_W | Word length in bits, 1..MAX_W |
| ready_i | input | 1 | Downstream accepts the presented word |
| valid_o | output | 1 | A word is presented |
| data_o | output | OUT_W | Sign-extended word |
| idx_o | output | IDX_W | Channel (0 or 1) or word number in frame |
| overrun_o | output | 1 | One-cycle pulse: an unaccepted word was replaced |

## Verification
A word's sampling edge reaches the decoder two system cycles after the pin moves, and the word is registered on the third edge. In the latency case the bench samples `valid_o` between edges after the second and after the third edge following the final bit clock transition, and expects low and then high. Elsewhere the bench changes pins only shortly after a falling clock edge. It holds each bit clock level for four system cycles and lets at least twelve cycles pass after a stream before comparing the collected words. The word log captures each handshake in the half-cycle before the rising edge that completes it, so the ready value it sees is the one the design uses.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [2:0] {
        FMT_I2S   = 3'd0,
        FMT_PCM_S = 3'd1,
        FMT_PCM_L = 3'd2,
        FMT_LJ    = 3'd3,
        FMT_RJ    = 3'd4
    } frame_e;

    localparam int BIT_LSB_FIRST = 3;
    localparam int BIT_SCK_INV   = 4;
    localparam int BIT_WS_INV    = 5;
    localparam int BIT_LOOP      = 7;

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = d_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.stable;

endmodule

// File: rtl/aud_rx_sext.sv
module aud_rx_sext #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 32,
    parameter int LEN_W = 6
) (
    input  logic [IN_W-1:0]  raw_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             lsb_first_i,
    output logic [OUT_W-1:0] data_o
);

    logic [IN_W-1:0]  aligned;
    logic [LEN_W-1:0] sign_pos;
    logic             sign;

    // LSB-first words collect at the top of the accumulator; bring them down
    always_comb begin
        aligned  = lsb_first_i ? (raw_i >> (IN_W - int'(len_i))) : raw_i;
        sign_pos = len_i - 1'b1;
        sign     = |(aligned & (IN_W'(1) << sign_pos));
    end

    for (genvar gi = 0; gi < OUT_W; gi++) begin : g_bit
        if (gi < IN_W) begin : g_in
            assign data_o[gi] = (gi < int'(len_i)) ? aligned[gi] : sign;
        end else begin : g_ext
            assign data_o[gi] = sign;
        end
    end

endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
    import aud_rx_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int OUT_W = 32,
    parameter int IDX_W = 3,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_i,
    input  logic             ws_i,
    input  logic             sd_i,
    input  logic             lb_sd_i,
    input  logic [7:0]       fmt_i,
    input  logic [7:0]       opt_i,
    input  logic [LEN_W-1:0] wlen_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [OUT_W-1:0] data_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             overrun_o
);

    typedef struct packed {
        logic             sck_p;   // previous decoded bit clock level
        logic             ws_p;    // word select at previous sampling edge
        logic             seen;    // at least one sampling edge since reset
        logic             arm;     // next sampling edge starts a word
        logic             busy;    // a word is being collected
        logic [LEN_W-1:0] cnt;
        logic [IDX_W-1:0] cur;
        logic [MAX_W-1:0] acc;
        logic             valid;
        logic [OUT_W-1:0] data;
        logic [IDX_W-1:0] idx;
        logic             ovr;
    } rx_t;

    rx_t s_d, s_q;

    logic             sd_sel;
    logic [2:0]       pins_s;
    logic             sck_now, ws_now, sd_now;
    logic [2:0]       code;
    logic             pcm, ev, chg;
    logic [MAX_W-1:0] shifted, raw;
    logic [OUT_W-1:0] ext;
    logic [LEN_W-1:0] wlen_c;
    logic             done, start, take;
    logic [IDX_W-1:0] start_idx, emit_idx;
    logic [LEN_W-1:0] cnt_n;
    logic             unused_cfg;

    assign unused_cfg = ^{opt_i[6:0], fmt_i[7:6]};

    assign sd_sel = opt_i[BIT_LOOP] ? lb_sd_i : sd_i;

    aud_rx_sync #(.N(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck_i, ws_i, sd_sel}),
        .q_o   (pins_s)
    );

    assign sck_now = pins_s[2] ^ fmt_i[BIT_SCK_INV];
    assign ws_now  = pins_s[1] ^ fmt_i[BIT_WS_INV];
    assign sd_now  = pins_s[0];
    assign code    = fmt_i[2:0];
    assign pcm     = (code == FMT_PCM_S) || (code == FMT_PCM_L);
    assign ev      = pcm ? (s_q.sck_p & ~sck_now) : (~s_q.sck_p & sck_now);
    assign chg     = s_q.seen && (ws_now != s_q.ws_p);
    assign shifted = fmt_i[BIT_LSB_FIRST] ? {sd_now, s_q.acc[MAX_W-1:1]}
                                          : {s_q.acc[MAX_W-2:0], sd_now};
    // right-justified words end before the bit seen with the change
    assign raw     = (code == FMT_RJ) ? s_q.acc : shifted;

    always_comb begin
        if (wlen_i == '0)                     wlen_c = LEN_W'(1);
        else if (int'(wlen_i) > MAX_W)        wlen_c = LEN_W'(MAX_W);
        else                                  wlen_c = wlen_i;
    end

    aud_rx_sext #(.IN_W(MAX_W), .OUT_W(OUT_W), .LEN_W(LEN_W)) u_sext (
        .raw_i       (raw),
        .len_i       (wlen_c),
        .lsb_first_i (fmt_i[BIT_LSB_FIRST]),
        .data_o      (ext)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ovr   = 1'b0;
        s_d.sck_p = sck_now;
        done      = 1'b0;
        start     = 1'b0;
        take      = 1'b0;
        start_idx = '0;
        emit_idx  = s_q.cur;
        cnt_n     = '0;
        if (ev) begin
            s_d.seen = 1'b1;
            s_d.ws_p = ws_now;
            case (code)
                FMT_I2S: begin
                    start     = s_q.arm;
                    take      = s_q.arm | s_q.busy;
                    start_idx = s_q.cur;
                end
                FMT_LJ: begin
                    start     = chg;
                    take      = chg | s_q.busy;
                    start_idx = IDX_W'(!ws_now);
                end
                FMT_PCM_S: begin
                    start = s_q.arm;
                    take  = s_q.arm | s_q.busy;
                end
                FMT_PCM_L: begin
                    start = s_q.seen & ws_now & ~s_q.ws_p;
                    take  = start | s_q.busy;
                end
                FMT_RJ: begin
                    s_d.acc = shifted;
                    if (chg) begin
                        done     = 1'b1;
                        emit_idx = IDX_W'(!s_q.ws_p);
                    end
                end
                default: ;
            endcase
            if (take) begin
                s_d.acc  = shifted;
                s_d.arm  = 1'b0;
                cnt_n    = (start ? '0 : s_q.cnt) + 1'b1;
                emit_idx = start ? start_idx : s_q.cur;
                if (cnt_n == wlen_c) begin
                    done     = 1'b1;
                    s_d.cnt  = '0;
                    s_d.busy = pcm;
                    s_d.cur  = pcm ? emit_idx + 1'b1 : emit_idx;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.cnt  = cnt_n;
                    s_d.cur  = emit_idx;
                end
            end
            if (code == FMT_I2S && chg) begin
                s_d.arm  = 1'b1;
                s_d.busy = 1'b0;
                s_d.cur  = IDX_W'(ws_now);
            end
            if (code == FMT_PCM_S && ws_now) begin
                s_d.arm  = 1'b1;
                s_d.busy = 1'b0;
            end
        end
        if (done) begin
            s_d.valid = 1'b1;
            s_d.data  = ext;
            s_d.idx   = emit_idx;
            s_d.ovr   = s_q.valid & ~ready_i;
        end else if (ready_i) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o   = s_q.valid;
    assign data_o    = s_q.data;
    assign idx_o     = s_q.idx;
    assign overrun_o = s_q.ovr;

    logic signed [OUT_W-1:0] high_part;
    assign high_part = $signed(data_o) >>> (wlen_c - 1'b1);

    assert_hold_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> valid_o);

    assert_hold_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !done) |=> $stable(data_o));

    assert_overrun_has_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> valid_o);

    assert_sign_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $stable(wlen_i)) |-> (high_part == '0 || high_part == '1));

    assert_stereo_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $stable(fmt_i) && (code == FMT_I2S || code == FMT_LJ || code == FMT_RJ))
        |-> (idx_o <= IDX_W'(1)));

    assert_reserved_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (code > 3'd4 && !valid_o) |=> !valid_o);

endmodule

// File: tb/tb_aud_ser_rx.sv
module tb_aud_ser_rx;

    localparam int MW = 32;
    localparam int OW = 32;
    localparam int IW = 3;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sck, ws, sd, lb;
    logic [7:0]    fmt_r, opt_r;
    logic [LW-1:0] wlen_r;
    logic          ready;
    logic          valid;
    logic [OW-1:0] data;
    logic [IW-1:0] idx;
    logic          overrun;

    always #4 clk = ~clk;

    aud_ser_rx #(.MAX_W(MW), .OUT_W(OW), .IDX_W(IW), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd), .lb_sd_i(lb),
        .fmt_i(fmt_r), .opt_i(opt_r), .wlen_i(wlen_r), .ready_i(ready),
        .valid_o(valid), .data_o(data), .idx_o(idx), .overrun_o(overrun)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int            ev_n;
    logic          ev_ws [0:1023];
    logic          ev_sd [0:1023];
    int            ex_n;
    logic [OW-1:0] ex_d [0:63];
    logic [IW-1:0] ex_i [0:63];
    int            got_n;
    logic [OW-1:0] got_d [0:63];
    logic [IW-1:0] got_i [0:63];
    int            ovr_n;
    logic [31:0]   vals [0:63];
    int            vi;

    // log a handshake just before the rising edge that completes it
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (valid && ready) begin
                if (got_n < 64) begin
                    got_d[got_n] = data;
                    got_i[got_n] = idx;
                end
                got_n++;
            end
            if (overrun) ovr_n++;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(logic [31:0] v, int wl);
        logic [31:0] m;
        m = (wl >= 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
        return (v & m) | (v[wl-1] ? ~m : 32'd0);
    endfunction

    function automatic logic tbit(logic [31:0] v, int k, int wl);
        return fmt_r[3] ? v[k] : v[wl-1-k];
    endfunction

    task automatic fill_vals();
        for (int k = 0; k < 64; k++)
            vals[k] = (32'h9E37_79B9 * (k + 5)) ^ (32'h5A5A_0000 >> (k % 16));
    endtask

    task automatic clear_lists();
        ev_n = 0; ex_n = 0; vi = 0;
    endtask

    task automatic push_ev(logic w, logic d);
        ev_ws[ev_n] = w; ev_sd[ev_n] = d; ev_n++;
    endtask

    task automatic push_exp(logic [31:0] v, int i, int wl);
        ex_d[ex_n] = sx(v, wl); ex_i[ex_n] = IW'(i); ex_n++;
    endtask

    task automatic build_i2s(int wl, int slot, int nfr);
        push_ev(1'b1, 1'b0); push_ev(1'b1, 1'b0);
        for (int f = 0; f < nfr; f++)
            for (int ch = 0; ch < 2; ch++) begin
                logic [31:0] v;
                v = vals[vi]; vi++;
                push_exp(v, ch, wl);
                for (int p = 0; p < slot; p++)
                    push_ev(ch[0], (p >= 1 && p - 1 < wl) ? tbit(v, p - 1, wl) : 1'b0);
            end
    endtask

    task automatic build_lj(int wl, int slot, int nfr);
        push_ev(1'b0, 1'b0); push_ev(1'b0, 1'b0);
        for (int f = 0; f < nfr; f++)
            for (int ch = 0; ch < 2; ch++) begin
                logic [31:0] v;
                v = vals[vi]; vi++;
                push_exp(v, ch, wl);
                for (int p = 0; p < slot; p++)
                    push_ev(~ch[0], (p < wl) ? tbit(v, p, wl) : 1'b0);
            end
    endtask

    task automatic build_rj(int wl, int slot, int nfr);
        for (int f = 0; f < nfr; f++)
            for (int ch = 0; ch < 2; ch++) begin
                logic [31:0] v;
                v = vals[vi]; vi++;
                push_exp(v, ch, wl);
                for (int p = 0; p < slot; p++)
                    push_ev(~ch[0], (p >= slot - wl) ? tbit(v, p - (slot - wl), wl) : 1'b1);
            end
        push_ev(1'b1, 1'b0);
    endtask

    task automatic build_pcms(int wl, int nw, int nfr);
        for (int f = 0; f < nfr; f++) begin
            push_ev(1'b1, 1'b1);
            for (int w = 0; w < nw; w++) begin
                logic [31:0] v;
                v = vals[vi]; vi++;
                push_exp(v, w, wl);
                for (int k = 0; k < wl; k++) push_ev(1'b0, tbit(v, k, wl));
            end
        end
    endtask

    task automatic build_pcml(int wl, int nw, int nfr, int hi);
        push_ev(1'b0, 1'b1);
        for (int f = 0; f < nfr; f++)
            for (int w = 0; w < nw; w++) begin
                logic [31:0] v;
                v = vals[vi]; vi++;
                push_exp(v, w, wl);
                for (int k = 0; k < wl; k++)
                    push_ev((w * wl + k) < hi, tbit(v, k, wl));
            end
    endtask

    task automatic set_pins_idle();
        logic idle;
        idle = (fmt_r[2:0] == 3'd1 || fmt_r[2:0] == 3'd2);
        sck = idle ^ fmt_r[4];
        ws  = fmt_r[5];
        sd  = 1'b0;
        lb  = 1'b0;
    endtask

    task automatic do_reset();
        set_pins_idle();
        rst_n = 1'b0;
        repeat (4) tick();
        rst_n = 1'b1;
        repeat (2) tick();
        got_n = 0;
        ovr_n = 0;
    endtask

    // one sampling edge per event; the pre-edge level is held 4 cycles each way
    task automatic play(bit probe);
        logic idle;
        idle = (fmt_r[2:0] == 3'd1 || fmt_r[2:0] == 3'd2);
        for (int i = 0; i < ev_n; i++) begin
            sck = idle ^ fmt_r[4];
            ws  = ev_ws[i] ^ fmt_r[5];
            if (opt_r[7]) begin lb = ev_sd[i]; sd = ~ev_sd[i]; end
            else          begin sd = ev_sd[i]; lb = ~ev_sd[i]; end
            repeat (4) tick();
            sck = ~idle ^ fmt_r[4];
            if (probe && i == ev_n - 1) begin
                tick(); tick();
                check(valid == 1'b0, "R1", "valid two edges after last bit", valid, 0);
                tick();
                check(valid == 1'b1, "R1", "valid three edges after last bit", valid, 1);
                tick();
            end else begin
                repeat (4) tick();
            end
        end
        repeat (12) tick();
    endtask

    task automatic compare(string req);
        check(got_n == ex_n, req, "word count", got_n, ex_n);
        for (int i = 0; i < ex_n && i < got_n; i++) begin
            check(got_d[i] == ex_d[i], req, $sformatf("data of word %0d", i), got_d[i], ex_d[i]);
            check(got_i[i] == ex_i[i], req, $sformatf("index of word %0d", i), got_i[i], ex_i[i]);
        end
    endtask

    task automatic run(logic [7:0] f, logic [7:0] o, int wl);
        fmt_r = f; opt_r = o; wlen_r = LW'(wl);
        do_reset();
        clear_lists();
    endtask

    initial begin
        rst_n = 1'b0; ready = 1'b1;
        fmt_r = 8'h00; opt_r = 8'h00; wlen_r = LW'(16);
        fill_vals();
        do_reset();

        // R11: reset state
        check(valid == 1'b0,   "R11", "valid after reset",   valid, 0);
        check(overrun == 1'b0, "R11", "overrun after reset", overrun, 0);
        check(data == '0,      "R11", "data after reset",    data, 0);
        check(idx == '0,       "R11", "index after reset",   idx, 0);

        // R2: stereo framing, several word lengths and slot widths
        for (int c = 0; c < 3; c++) begin
            int wl;
            wl = (c == 0) ? 16 : (c == 1) ? 8 : 24;
            run(8'h00, 8'h00, wl);
            build_i2s(wl, wl + 1 + 3 * c, 2);
            play(0);
            compare("R2");
        end

        // R8: both pin polarities inverted
        run(8'h30, 8'h00, 12);
        build_i2s(12, 14, 2);
        play(0);
        compare("R8");

        // R3: left-justified, then R7 LSB first
        run(8'h03, 8'h00, 12);
        build_lj(12, 16, 2);
        play(0);
        compare("R3");
        run(8'h0B, 8'h00, 10);
        build_lj(10, 13, 2);
        play(0);
        compare("R7");

        // R4: right-justified, padded and exact slots
        run(8'h04, 8'h00, 10);
        build_rj(10, 16, 2);
        play(0);
        compare("R4");
        run(8'h0C, 8'h00, 16);
        build_rj(16, 16, 1);
        play(0);
        compare("R4");

        // R5: short sync, back-to-back words
        run(8'h01, 8'h00, 8);
        build_pcms(8, 3, 2);
        play(0);
        compare("R5");
        run(8'h11, 8'h00, 5);
        build_pcms(5, 4, 1);
        play(0);
        compare("R5");

        // R6: long sync, LSB first and MSB first
        run(8'h0A, 8'h00, 8);
        build_pcml(8, 4, 2, 3);
        play(0);
        compare("R6");
        run(8'h22, 8'h00, 6);
        build_pcml(6, 3, 2, 9);
        play(0);
        compare("R6");

        // R9: loopback path feeds data, external data inverted
        run(8'h00, 8'h80, 16);
        build_i2s(16, 18, 2);
        play(0);
        compare("R9");
        run(8'h00, 8'h00, 16);
        build_i2s(16, 18, 1);
        play(0);
        compare("R9");

        // R10: sign extension of chosen extremes
        vals[0] = 32'h0000_0080; vals[1] = 32'h0000_007F;
        vals[2] = 32'h0000_0001; vals[3] = 32'h0000_00FF;
        run(8'h02, 8'h00, 8);
        build_pcml(8, 4, 1, 2);
        play(0);
        compare("R10");
        check(got_d[0] == 32'hFFFF_FF80, "R10", "negative extreme", got_d[0], 32'hFFFF_FF80);
        check(got_d[1] == 32'h0000_007F, "R10", "positive extreme", got_d[1], 32'h0000_007F);
        fill_vals();

        // R1: output latency after the final bit clock edge
        run(8'h01, 8'h00, 4);
        build_pcms(4, 1, 1);
        play(1);
        compare("R1");

        // R11: overrun with downstream stalled
        run(8'h01, 8'h00, 8);
        ready = 1'b0;
        build_pcms(8, 3, 1);
        play(0);
        check(ovr_n == 2,        "R11", "overrun pulses", ovr_n, 2);
        check(valid == 1'b1,     "R11", "valid held",     valid, 1);
        check(data == ex_d[2],   "R11", "latest word kept", data, ex_d[2]);
        check(idx == IW'(2),     "R11", "latest index kept", idx, 2);
        ready = 1'b1;
        tick(); tick();
        check(got_n == 1,        "R11", "one word accepted", got_n, 1);
        check(valid == 1'b0,     "R11", "valid cleared",  valid, 0);

        // R12: reserved framing code yields nothing
        run(8'h05, 8'h00, 8);
        build_i2s(8, 10, 2);
        play(0);
        check(got_n == 0,        "R12", "words from code 5", got_n, 0);
        check(valid == 1'b0,     "R12", "valid with code 5", valid, 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule